// File: doc/BRIEF.md
# Write-Protected Lookup-Table DAC Controller

This block turns an 8-bit converter sample into a DAC code through a 64-row, 8-bit lookup table. The table row is picked either by the upper six bits of the sample or by a row number held in a control byte. The DAC code is either the selected row's contents or a fixed byte held in another control byte. All storage sits behind a simple byte bus with address, write data, write and read strobes, read data and a per-byte acknowledge.

Every write passes through a volatile write-enable latch that comes out of reset cleared. Two exact byte values written to the configuration byte set and clear the latch. Those two writes are always accepted. While the latch is clear, every other write is dropped and gets no acknowledge. Non-volatile settings are modelled as flops that reset to their defaults.

Address map: table rows at 00h–3Fh, fixed DAC byte at 84h, row-control byte at 85h, configuration byte at 86h, and the read-only sample status at 87h. Bus responses (`ack_o`, `rdata_o`) are registered and appear in the cycle after the strobe. If both strobes are high in the same cycle, the write takes precedence.

Top module: `lut_dac_ctrl`

## Requirements
- R1: After reset the write-enable latch (86h bit 7) is 0, bytes 84h, 85h and 86h read 00h, all table rows are 00h, `ack_o` is 0 and `dac_code_o` is 00h.
- R2: A write of exactly 80h to 86h sets the latch, and a write of exactly 00h clears it. Both are acknowledged whatever the latch state.
- R3: A latch-setting or latch-clearing write leaves 86h bits 6:0 unchanged. With the latch set, any other byte written to 86h replaces bits 6:0 and keeps bit 7. Bit 0 is the DAC source select.
- R4: With the latch clear, writes to the table, 84h, 85h, or any other byte to 86h are not acknowledged and change no storage.
- R5: With the latch set, table rows 00h–3Fh are writable and acknowledged. A read of any address is acknowledged, with its data on `rdata_o` in the next cycle.
- R6: When 85h bit 7 is 0, the table row is `adc_i[7:2]`. When it is 1, the row is 85h bits 5:0.
- R7: When 86h bit 0 is 0, the DAC code is the selected table row. When it is 1, the DAC code is the contents of 84h.
- R8: A read of 87h returns `adc_i` (00h for minimum, FFh for full scale). A write to 87h is not acknowledged and has no effect.
- R9: Reads of unmapped addresses return 00h with acknowledge. Writes to unmapped addresses are not acknowledged.
- R10: `dac_code_o` follows a change of the sample, the select bits, the direct row, 84h or the selected table entry exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one byte per cycle |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after `re_i` |
| ack_o | output | 1 | Acknowledge for the byte of the previous cycle |
| adc_i | input | 8 | Converter sample |
| dac_code_o | output | 8 | Registered DAC code |

## Verification
The hardest cases to reach are the ones where the lock silently drops a write. From the ports, such a write shows only as a missing acknowledge plus unchanged storage. The bench therefore pairs each locked write with a read-back of the target byte, or with a look at `dac_code_o` while that byte is the DAC source. It also interleaves latch set/clear writes with configuration writes, so that bits 6:0 of 86h must survive both latch patterns. The table-path sweeps walk every sample value and every direct row against a closed-form table fill.

// File: rtl/lutdac_pkg.sv
package lutdac_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ROW_W  = 6;
  localparam logic [ADDR_W-1:0] A_DAC_BYTE = 8'h84;
  localparam logic [ADDR_W-1:0] A_ROW_CTL  = 8'h85;
  localparam logic [ADDR_W-1:0] A_CFG      = 8'h86;
  localparam logic [ADDR_W-1:0] A_STATUS   = 8'h87;
  localparam logic [DATA_W-1:0] WEN_SET    = 8'h80;
  localparam logic [DATA_W-1:0] WEN_CLR    = 8'h00;
endpackage

// File: rtl/lutdac_table.sv
module lutdac_table #(
  parameter int unsigned DW = 8,
  parameter int unsigned RW = 6,
  localparam int unsigned DEPTH = 1 << RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [RW-1:0] bus_addr_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [RW-1:0] row_i,
  output logic [DW-1:0] row_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && waddr_i == RW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign bus_rdata_o = mem_q[bus_addr_i];
  assign row_data_o  = mem_q[row_i];
endmodule

// File: rtl/lutdac_regs.sv
module lutdac_regs
  import lutdac_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned RW = ROW_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] adc_i,
  input  logic [DW-1:0] tbl_rdata_i,
  output logic          tbl_we_o,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  output logic [DW-1:0] dac_byte_o,
  output logic [RW-1:0] row_direct_o,
  output logic          row_sel_o,
  output logic          dac_sel_o
);
  logic          wen_q;
  logic [DW-2:0] cfg_q;
  logic [DW-1:0] dac_q, row_q, rd_mux;
  logic          is_tbl, is_dac, is_row, is_cfg, is_sts, wen_pat, accept, rd_only;

  assign is_tbl  = addr_i[AW-1:RW] == '0;
  assign is_dac  = addr_i == A_DAC_BYTE;
  assign is_row  = addr_i == A_ROW_CTL;
  assign is_cfg  = addr_i == A_CFG;
  assign is_sts  = addr_i == A_STATUS;
  assign wen_pat = is_cfg && (wdata_i == WEN_SET || wdata_i == WEN_CLR);
  // latch patterns bypass the lock; everything else needs it
  assign accept  = we_i && (wen_pat || (wen_q && (is_tbl || is_dac || is_row || is_cfg)));
  assign rd_only = re_i && !we_i;
  assign tbl_we_o = we_i && is_tbl && wen_q;

  always_comb begin
    rd_mux = '0;
    if (is_tbl)      rd_mux = tbl_rdata_i;
    else if (is_dac) rd_mux = dac_q;
    else if (is_row) rd_mux = row_q;
    else if (is_cfg) rd_mux = {wen_q, cfg_q};
    else if (is_sts) rd_mux = adc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q   <= 1'b0;
      cfg_q   <= '0;
      dac_q   <= '0;
      row_q   <= '0;
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      if (accept && is_cfg) begin
        if (wen_pat) wen_q <= wdata_i[DW-1];
        else         cfg_q <= wdata_i[DW-2:0];
      end
      if (accept && is_dac) dac_q <= wdata_i;
      if (accept && is_row) row_q <= wdata_i;
      ack_o   <= accept || rd_only;
      rdata_o <= rd_only ? rd_mux : '0;
    end
  end

  assign dac_byte_o   = dac_q;
  assign row_direct_o = row_q[RW-1:0];
  assign row_sel_o    = row_q[DW-1];
  assign dac_sel_o    = cfg_q[0];

  a_r2_wen_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_cfg && wdata_i == WEN_SET |=> wen_q && ack_o);
  a_r2_wen_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_cfg && wdata_i == WEN_CLR |=> !wen_q && ack_o);
  a_r3_cfg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wen_pat |=> $stable(cfg_q));
  a_r4_locked_nak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !wen_q && !wen_pat |=> !ack_o && $stable(dac_q) && $stable(row_q) && $stable(cfg_q));
  a_r8_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_sts |=> !ack_o);
  a_r9_unmapped_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_only && !(is_tbl || is_dac || is_row || is_cfg || is_sts) |=> ack_o && rdata_o == '0);
endmodule

// File: rtl/lut_dac_ctrl.sv
module lut_dac_ctrl
  import lutdac_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned RW = ROW_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  input  logic [DW-1:0] adc_i,
  output logic [DW-1:0] dac_code_o
);
  logic          tbl_we, row_sel, dac_sel;
  logic [DW-1:0] tbl_bus_data, tbl_row_data, dac_byte, dac_d;
  logic [RW-1:0] row_direct, row;

  lutdac_regs #(.AW(AW), .DW(DW), .RW(RW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .adc_i,
    .tbl_rdata_i (tbl_bus_data),
    .tbl_we_o    (tbl_we),
    .rdata_o, .ack_o,
    .dac_byte_o  (dac_byte),
    .row_direct_o(row_direct),
    .row_sel_o   (row_sel),
    .dac_sel_o   (dac_sel)
  );

  assign row = row_sel ? row_direct : adc_i[DW-1 -: RW];

  lutdac_table #(.DW(DW), .RW(RW)) u_table (
    .clk_i, .rst_ni,
    .we_i       (tbl_we),
    .waddr_i    (addr_i[RW-1:0]),
    .wdata_i    (wdata_i),
    .bus_addr_i (addr_i[RW-1:0]),
    .bus_rdata_o(tbl_bus_data),
    .row_i      (row),
    .row_data_o (tbl_row_data)
  );

  assign dac_d = dac_sel ? dac_byte : tbl_row_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_code_o <= '0;
    else         dac_code_o <= dac_d;
  end

  a_r7_dac_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_sel |=> dac_code_o == $past(dac_byte));
  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_sel |=> dac_code_o == $past(tbl_row_data));
endmodule

// File: tb/lut_dac_ctrl_tb.sv
module lut_dac_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, adc = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata, dac;
  logic       ack;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  lut_dac_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .ack_o(ack),
    .adc_i(adc), .dac_code_o(dac)
  );

  function automatic logic [7:0] fill(int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
    end
  endtask

  task automatic wr(string rq, logic [7:0] a, logic [7:0] d, logic exp_ack);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk(rq, {7'd0, ack}, {7'd0, exp_ack});
  endtask

  task automatic rd(string rq, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    chk(rq, {7'd0, ack}, 8'd1);
    chk(rq, rdata, exp);
  endtask

  task automatic set_adc(logic [7:0] v);
    @(negedge clk); adc = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {7'd0, ack}, 8'd0);
    chk("R1", dac, 8'h00);
    rd("R1", 8'h86, 8'h00);
    rd("R1", 8'h84, 8'h00);
    rd("R1", 8'h85, 8'h00);
    rd("R1", 8'h10, 8'h00);
    // R4 locked writes dropped
    wr("R4", 8'h03, 8'h5A, 1'b0);
    rd("R4", 8'h03, 8'h00);
    wr("R4", 8'h84, 8'h77, 1'b0);
    rd("R4", 8'h84, 8'h00);
    wr("R4", 8'h85, 8'h81, 1'b0);
    rd("R4", 8'h85, 8'h00);
    wr("R4", 8'h86, 8'h41, 1'b0);
    rd("R4", 8'h86, 8'h00);
    // R2 set latch
    wr("R2", 8'h86, 8'h80, 1'b1);
    rd("R2", 8'h86, 8'h80);
    wr("R2", 8'h86, 8'h80, 1'b1);
    rd("R2", 8'h86, 8'h80);
    // R5 fill table, read back
    for (int i = 0; i < 64; i++) wr("R5", 8'(i), fill(i), 1'b1);
    for (int i = 0; i < 64; i++) rd("R5", 8'(i), fill(i));
    // R6 / R10 sample-driven row sweep
    for (int v = 0; v < 256; v++) begin
      set_adc(8'(v));
      chk("R6", dac, fill(v >> 2));
    end
    // R10 exact latency: previous value until first edge
    @(negedge clk); adc = 8'h00;
    @(negedge clk); adc = 8'hFF;
    chk("R10", dac, fill(0));
    @(posedge clk); #1;
    chk("R10", dac, fill(63));
    // R8 status
    rd("R8", 8'h87, 8'hFF);
    set_adc(8'h00);
    rd("R8", 8'h87, 8'h00);
    set_adc(8'h9C);
    wr("R8", 8'h87, 8'h12, 1'b0);
    rd("R8", 8'h87, 8'h9C);
    // R9 unmapped
    rd("R9", 8'h40, 8'h00);
    rd("R9", 8'hFF, 8'h00);
    rd("R9", 8'h83, 8'h00);
    wr("R9", 8'h88, 8'h55, 1'b0);
    wr("R9", 8'h40, 8'h55, 1'b0);
    // R6 direct row sweep (85h bit7 select, bits5:0 row)
    set_adc(8'h00);
    for (int r = 0; r < 64; r++) begin
      wr("R6", 8'h85, 8'h80 | 8'(r), 1'b1);
      @(negedge clk);
      chk("R6", dac, fill(r));
    end
    rd("R6", 8'h85, 8'hBF);
    wr("R6", 8'h85, 8'h3F, 1'b1);
    set_adc(8'h20);
    chk("R6", dac, fill(8));
    // R10 table entry change propagates
    wr("R10", 8'h08, 8'hE1, 1'b1);
    @(negedge clk);
    chk("R10", dac, 8'hE1);
    // R3 config bits vs latch patterns; R7 DAC source
    wr("R7", 8'h84, 8'hC3, 1'b1);
    wr("R3", 8'h86, 8'hC1, 1'b1);
    rd("R3", 8'h86, 8'hC1);
    @(negedge clk);
    chk("R7", dac, 8'hC3);
    for (int k = 0; k < 8; k++) begin
      wr("R7", 8'h84, 8'(k * 29 + 1), 1'b1);
      @(negedge clk);
      chk("R7", dac, 8'(k * 29 + 1));
    end
    wr("R3", 8'h86, 8'h00, 1'b1);
    rd("R3", 8'h86, 8'h41);
    // locked: DAC byte and config untouched
    wr("R4", 8'h84, 8'h11, 1'b0);
    @(negedge clk);
    chk("R4", dac, 8'(7 * 29 + 1));
    wr("R4", 8'h86, 8'h02, 1'b0);
    rd("R4", 8'h86, 8'h41);
    wr("R4", 8'h08, 8'h22, 1'b0);
    rd("R4", 8'h08, 8'hE1);
    wr("R3", 8'h86, 8'h80, 1'b1);
    rd("R3", 8'h86, 8'hC1);
    wr("R3", 8'h86, 8'h02, 1'b1);
    rd("R3", 8'h86, 8'h82);
    @(negedge clk);
    chk("R7", dac, 8'hE1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule